// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath with Fetch Sequencer

This block is the datapath of a small accumulator computer. Six registers and a 4096-word by 16-bit memory exchange data over one 16-bit shared bus. A 3-bit source code chooses which unit drives the bus. Every destination register has its own load, increment and clear strobes. The instruction register is the exception and can only load. The address register feeds the memory address directly, not through the bus. A control unit outside the block drives the strobes and the source code cycle by cycle.

A built-in sequencer handles instruction fetch and taken branches by itself. While it runs, it takes over the bus and the strobes. A fetch lasts three clocks: first the program counter is copied to the address register; then the addressed word goes to the instruction register while the program counter steps by one; then the address field of the instruction (bits 11 to 0) goes to the address register. A taken branch copies that same address field into the program counter in a single clock. A separate memory load port lets a program and its data be placed in memory.

Top module: `acc_bus_datapath`

## Requirements
- R1: After a synchronous active-high reset, the registers AR, PC, DR, AC, IR and TR all read zero and `fetch_busy` is low.
- R2: The bus carries zero for source code 0, and AR, PC, DR, AC, IR, TR and memory word mem[AR] for codes 1 to 7 in that order. The 12-bit registers AR and PC drive the bus with bits 15 to 12 at zero.
- R3: A register whose load strobe is high takes the bus value on the clock edge. AR and PC keep only bus bits 11 to 0.
- R4: An increment strobe adds one, wrapping modulo the register width (16'hFFFF+1=0, 12'hFFF+1=0). A clear strobe gives zero. Clear has priority over load, and load has priority over increment.
- R5: When `mem_wr` is high, the bus value is written into mem[AR] on the clock edge. Memory reads are combinational from AR.
- R6: When `load_en` is high, `load_data` is written at `load_addr`. If `mem_wr` is high in the same cycle, the bus write is dropped.
- R7: When the sequencer is idle and `fetch_start` is high, a fetch runs. In cycle T0 (the start cycle) AR takes PC. In T1, IR takes mem[AR] and PC increments, wrapping from 12'hFFF to 0. In T2, AR takes IR bits 11 to 0. `fetch_busy` is high after the T0 edge and after the T1 edge, and low after the T2 edge.
- R8: While the sequencer drives the datapath, the external source code, the register strobes and `mem_wr` have no effect. This covers T0, T1, T2 and the branch cycle. `fetch_start` and `branch_take` are ignored while `fetch_busy` is high.
- R9: When the sequencer is idle, `branch_take` is high and `fetch_start` is low, PC takes IR bits 11 to 0 on that clock edge. IR bits 15 to 12 (the operation code) are not used. If both `branch_take` and `fetch_start` are high, the fetch starts and no branch happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source code |
| ar_ld | input | 1 | AR load from bus |
| ar_inr | input | 1 | AR increment |
| ar_clr | input | 1 | AR clear |
| pc_ld | input | 1 | PC load from bus |
| pc_inr | input | 1 | PC increment |
| pc_clr | input | 1 | PC clear |
| dr_ld | input | 1 | DR load from bus |
| dr_inr | input | 1 | DR increment |
| dr_clr | input | 1 | DR clear |
| ac_ld | input | 1 | AC load from bus |
| ac_inr | input | 1 | AC increment |
| ac_clr | input | 1 | AC clear |
| ir_ld | input | 1 | IR load from bus |
| tr_ld | input | 1 | TR load from bus |
| tr_inr | input | 1 | TR increment |
| tr_clr | input | 1 | TR clear |
| mem_wr | input | 1 | Write the bus value into mem[AR] |
| fetch_start | input | 1 | Start an instruction fetch |
| branch_take | input | 1 | Load PC from the IR address field |
| load_en | input | 1 | Memory load port write enable |
| load_addr | input | 12 | Memory load port address |
| load_data | input | 16 | Memory load port data |
| bus_out | output | 16 | Current shared-bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| fetch_busy | output | 1 | Fetch in cycle T1 or T2 |

## Verification
The hardest case to reach from the ports is showing that external strobes are ignored while the sequencer owns the datapath. The override changes which source drives the bus, so a stray memory write during a fetch would often store the very value already at that address and leave no trace. The stimulus avoids this by putting a marker word at the address the T0 cycle points to. During the whole fetch it holds clear strobes and a memory write of the accumulator. Afterwards it confirms that the marker word, AC and DR are unchanged. A second sequence raises fetch and branch together, with an IR whose address field differs from PC, to show that the fetch wins.

// File: rtl/acc_bus_pkg.sv
package acc_bus_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_t;

  typedef struct packed {
    logic     ar_ld;
    logic     ar_inr;
    logic     ar_clr;
    logic     pc_ld;
    logic     pc_inr;
    logic     pc_clr;
    logic     dr_ld;
    logic     dr_inr;
    logic     dr_clr;
    logic     ac_ld;
    logic     ac_inr;
    logic     ac_clr;
    logic     ir_ld;
    logic     tr_ld;
    logic     tr_inr;
    logic     tr_clr;
    logic     mem_wr;
    bus_src_t sel;
  } xfer_ctl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2
  } fetch_ph_t;

endpackage

// File: rtl/acc_bus_reg.sv
module acc_bus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         inr,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inr) q <= q + ONE;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> (q == $past(d)));

  assert_incr_R4: assert property (@(posedge clk) disable iff (rst)
    (inr && !ld && !clr) |=> (q == $past(q) + ONE));

endmodule

// File: rtl/acc_bus_mem.sv
module acc_bus_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux
  import acc_bus_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  bus_src_t      sel,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] dr,
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] tr,
  input  logic [DW-1:0] md,
  output logic [DW-1:0] bus
);

  localparam int PAD = DW - AW;

  always_comb begin
    case (sel)
      SRC_AR:  bus = {{PAD{1'b0}}, ar};
      SRC_PC:  bus = {{PAD{1'b0}}, pc};
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = md;
      default: bus = '0;
    endcase
  end

endmodule

// File: rtl/acc_bus_seq.sv
module acc_bus_seq
  import acc_bus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      branch,
  output logic      active,
  output xfer_ctl_t ctl,
  output logic      busy
);

  fetch_ph_t state, nxt;

  always_comb begin
    ctl    = '0;
    active = 1'b0;
    nxt    = PH_IDLE;
    case (state)
      PH_IDLE: begin
        if (start) begin
          active     = 1'b1;
          ctl.sel    = SRC_PC;
          ctl.ar_ld  = 1'b1;
          nxt        = PH_T1;
        end else if (branch) begin
          active     = 1'b1;
          ctl.sel    = SRC_IR;
          ctl.pc_ld  = 1'b1;
        end
      end
      PH_T1: begin
        active     = 1'b1;
        ctl.sel    = SRC_MEM;
        ctl.ir_ld  = 1'b1;
        ctl.pc_inr = 1'b1;
        nxt        = PH_T2;
      end
      PH_T2: begin
        active     = 1'b1;
        ctl.sel    = SRC_IR;
        ctl.ar_ld  = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_IDLE;
    else     state <= nxt;
  end

  assign busy = (state != PH_IDLE);

  assert_start_to_t1_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PH_IDLE && start) |=> (state == PH_T1));

  assert_t1_to_t2_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PH_T1) |=> (state == PH_T2));

  assert_t2_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PH_T2) |=> (state == PH_IDLE));

endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
  import acc_bus_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bus_sel,
  input  logic          ar_ld,
  input  logic          ar_inr,
  input  logic          ar_clr,
  input  logic          pc_ld,
  input  logic          pc_inr,
  input  logic          pc_clr,
  input  logic          dr_ld,
  input  logic          dr_inr,
  input  logic          dr_clr,
  input  logic          ac_ld,
  input  logic          ac_inr,
  input  logic          ac_clr,
  input  logic          ir_ld,
  input  logic          tr_ld,
  input  logic          tr_inr,
  input  logic          tr_clr,
  input  logic          mem_wr,
  input  logic          fetch_start,
  input  logic          branch_take,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] bus_out,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] dr_q,
  output logic [DW-1:0] ac_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] tr_q,
  output logic          fetch_busy
);

  xfer_ctl_t     ext_ctl, seq_ctl, eff;
  logic          seq_active;
  logic [DW-1:0] bus, mem_q;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  always_comb begin
    ext_ctl.ar_ld  = ar_ld;
    ext_ctl.ar_inr = ar_inr;
    ext_ctl.ar_clr = ar_clr;
    ext_ctl.pc_ld  = pc_ld;
    ext_ctl.pc_inr = pc_inr;
    ext_ctl.pc_clr = pc_clr;
    ext_ctl.dr_ld  = dr_ld;
    ext_ctl.dr_inr = dr_inr;
    ext_ctl.dr_clr = dr_clr;
    ext_ctl.ac_ld  = ac_ld;
    ext_ctl.ac_inr = ac_inr;
    ext_ctl.ac_clr = ac_clr;
    ext_ctl.ir_ld  = ir_ld;
    ext_ctl.tr_ld  = tr_ld;
    ext_ctl.tr_inr = tr_inr;
    ext_ctl.tr_clr = tr_clr;
    ext_ctl.mem_wr = mem_wr;
    ext_ctl.sel    = bus_src_t'(bus_sel);
  end

  acc_bus_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (fetch_start),
    .branch (branch_take),
    .active (seq_active),
    .ctl    (seq_ctl),
    .busy   (fetch_busy)
  );

  assign eff = seq_active ? seq_ctl : ext_ctl;

  acc_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .sel (eff.sel),
    .ar  (ar_q),
    .pc  (pc_q),
    .dr  (dr_q),
    .ac  (ac_q),
    .ir  (ir_q),
    .tr  (tr_q),
    .md  (mem_q),
    .bus (bus)
  );

  assign bus_out = bus;

  acc_bus_reg #(.W(AW)) u_ar (
    .clk(clk), .rst(rst), .ld(eff.ar_ld), .inr(eff.ar_inr), .clr(eff.ar_clr),
    .d(bus[AW-1:0]), .q(ar_q));

  acc_bus_reg #(.W(AW)) u_pc (
    .clk(clk), .rst(rst), .ld(eff.pc_ld), .inr(eff.pc_inr), .clr(eff.pc_clr),
    .d(bus[AW-1:0]), .q(pc_q));

  acc_bus_reg #(.W(DW)) u_dr (
    .clk(clk), .rst(rst), .ld(eff.dr_ld), .inr(eff.dr_inr), .clr(eff.dr_clr),
    .d(bus), .q(dr_q));

  acc_bus_reg #(.W(DW)) u_ac (
    .clk(clk), .rst(rst), .ld(eff.ac_ld), .inr(eff.ac_inr), .clr(eff.ac_clr),
    .d(bus), .q(ac_q));

  acc_bus_reg #(.W(DW)) u_ir (
    .clk(clk), .rst(rst), .ld(eff.ir_ld), .inr(1'b0), .clr(1'b0),
    .d(bus), .q(ir_q));

  acc_bus_reg #(.W(DW)) u_tr (
    .clk(clk), .rst(rst), .ld(eff.tr_ld), .inr(eff.tr_inr), .clr(eff.tr_clr),
    .d(bus), .q(tr_q));

  assign mem_we    = load_en | eff.mem_wr;
  assign mem_waddr = load_en ? load_addr : ar_q;
  assign mem_wdata = load_en ? load_data : bus;

  acc_bus_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ar_q),
    .rdata (mem_q)
  );

  assert_fetch_t0_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_start && !fetch_busy) |=> (ar_q == $past(pc_q)));

  assert_branch_R9: assert property (@(posedge clk) disable iff (rst)
    (branch_take && !fetch_start && !fetch_busy) |=> (pc_q == $past(ir_q[AW-1:0])));

  assert_ext_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (fetch_busy || fetch_start || branch_take) |=>
      ($stable(ac_q) && $stable(dr_q) && $stable(tr_q)));

endmodule

// File: tb/tb_acc_bus_datapath.sv
module tb_acc_bus_datapath;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_sel;
  logic        ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr;
  logic        dr_ld, dr_inr, dr_clr, ac_ld, ac_inr, ac_clr;
  logic        ir_ld, tr_ld, tr_inr, tr_clr, mem_wr;
  logic        fetch_start, branch_take, load_en;
  logic [11:0] load_addr;
  logic [15:0] load_data;
  logic [15:0] bus_out, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  logic        fetch_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_bus_datapath dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel),
    .ar_ld(ar_ld), .ar_inr(ar_inr), .ar_clr(ar_clr),
    .pc_ld(pc_ld), .pc_inr(pc_inr), .pc_clr(pc_clr),
    .dr_ld(dr_ld), .dr_inr(dr_inr), .dr_clr(dr_clr),
    .ac_ld(ac_ld), .ac_inr(ac_inr), .ac_clr(ac_clr),
    .ir_ld(ir_ld), .tr_ld(tr_ld), .tr_inr(tr_inr), .tr_clr(tr_clr),
    .mem_wr(mem_wr), .fetch_start(fetch_start), .branch_take(branch_take),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .bus_out(bus_out), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
    .ir_q(ir_q), .tr_q(tr_q), .fetch_busy(fetch_busy)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 40503 + 23130);
  endfunction

  task automatic clr_ctl;
    bus_sel = 3'd0;
    {ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr} = '0;
    {dr_ld, dr_inr, dr_clr, ac_ld, ac_inr, ac_clr} = '0;
    {ir_ld, tr_ld, tr_inr, tr_clr, mem_wr} = '0;
    {fetch_start, branch_take, load_en} = '0;
    load_addr = '0;
    load_data = '0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic memw(input logic [11:0] a, input logic [15:0] v);
    load_en = 1'b1; load_addr = a; load_data = v;
    tick;
    load_en = 1'b0;
  endtask

  // dst: 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR (uses mem[0] as scratch)
  task automatic put(input int dst, input logic [15:0] v);
    memw(12'h000, v);
    ar_clr = 1'b1; tick; ar_clr = 1'b0;
    bus_sel = 3'd7;
    case (dst)
      1: ar_ld = 1'b1;
      2: pc_ld = 1'b1;
      3: dr_ld = 1'b1;
      4: ac_ld = 1'b1;
      5: ir_ld = 1'b1;
      default: tr_ld = 1'b1;
    endcase
    tick;
    clr_ctl;
  endtask

  task automatic read_mem(input string req, input logic [11:0] a, input logic [15:0] exp);
    put(1, {4'h0, a});
    bus_sel = 3'd7;
    #1 chk(req, bus_out, exp);
    bus_sel = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_bus [8];
    clr_ctl;
    rst = 1'b1;
    repeat (3) tick;
    rst = 1'b0;
    #1;
    chk("R1 ar", {4'h0, ar_q}, 16'h0);
    chk("R1 pc", {4'h0, pc_q}, 16'h0);
    chk("R1 dr", dr_q, 16'h0);
    chk("R1 ac", ac_q, 16'h0);
    chk("R1 ir", ir_q, 16'h0);
    chk("R1 tr", tr_q, 16'h0);
    chk("R1 busy", {15'h0, fetch_busy}, 16'h0);
    chk("R2 sel0", bus_out, 16'h0);

    // R6: fill all memory through the load port
    for (int a = 0; a < 4096; a++) memw(12'(a), pat(a));

    // R2/R3/R4: exhaustive read sweep, AR stepping by increment
    ar_clr = 1'b1; tick; clr_ctl;
    for (int a = 0; a < 4096; a++) begin
      bus_sel = 3'd7;
      #1 chk("R2 mem source", bus_out, pat(a));
      dr_ld = 1'b1; ar_inr = 1'b1;
      tick;
      chk("R3 dr load", dr_q, pat(a));
      chk("R4 ar step", {4'h0, ar_q}, 16'(((a + 1) % 4096)));
      clr_ctl;
    end

    // R2/R3: every bus source
    put(2, 16'hABCD);
    put(3, 16'h1357);
    put(4, 16'h2468);
    put(5, 16'h9876);
    put(6, 16'hC0DE);
    put(1, 16'hFFFF);
    chk("R3 ar truncation", {4'h0, ar_q}, 16'h0FFF);
    chk("R3 pc truncation", {4'h0, pc_q}, 16'h0BCD);
    exp_bus[0] = 16'h0000; exp_bus[1] = 16'h0FFF; exp_bus[2] = 16'h0BCD;
    exp_bus[3] = 16'h1357; exp_bus[4] = 16'h2468; exp_bus[5] = 16'h9876;
    exp_bus[6] = 16'hC0DE; exp_bus[7] = pat(4095);
    for (int s = 0; s < 8; s++) begin
      bus_sel = 3'(s);
      #1 chk("R2 source sweep", bus_out, exp_bus[s]);
    end
    clr_ctl;

    // R4: wrap, priorities
    ar_inr = 1'b1; tick; clr_ctl;
    chk("R4 ar wrap", {4'h0, ar_q}, 16'h0);
    put(4, 16'hFFFF);
    ac_inr = 1'b1; tick; clr_ctl;
    chk("R4 ac wrap", ac_q, 16'h0);
    put(3, 16'h00FF);
    dr_inr = 1'b1; repeat (3) tick; clr_ctl;
    chk("R4 dr count", dr_q, 16'h0102);
    memw(12'h000, 16'h1111);
    ar_clr = 1'b1; tick; clr_ctl;
    bus_sel = 3'd7; ac_ld = 1'b1; ac_inr = 1'b1; tick; clr_ctl;
    chk("R4 load over inc", ac_q, 16'h1111);
    bus_sel = 3'd7; ac_ld = 1'b1; ac_clr = 1'b1; tick; clr_ctl;
    chk("R4 clear over load", ac_q, 16'h0);
    tr_clr = 1'b1; tick; clr_ctl;
    chk("R4 tr clear", tr_q, 16'h0);
    tr_inr = 1'b1; tick; clr_ctl;
    chk("R4 tr inc", tr_q, 16'h0001);
    pc_clr = 1'b1; tick; clr_ctl;
    chk("R4 pc clear", {4'h0, pc_q}, 16'h0);

    // R5: bus write into mem[AR]
    put(4, 16'h7E57);
    put(1, 16'h0123);
    bus_sel = 3'd4; mem_wr = 1'b1; tick; clr_ctl;
    read_mem("R5 write", 12'h123, 16'h7E57);

    // R6: load port wins over bus write
    put(4, 16'h3333);
    put(1, 16'h0123);
    bus_sel = 3'd4; mem_wr = 1'b1;
    load_en = 1'b1; load_addr = 12'h200; load_data = 16'h0BAD;
    tick; clr_ctl;
    read_mem("R6 bus write dropped", 12'h123, 16'h7E57);
    read_mem("R6 load write", 12'h200, 16'h0BAD);

    // R7/R8: fetch with hostile external controls
    memw(12'h345, 16'h7ABC);
    put(2, 16'h0345);
    put(4, 16'h2222);
    put(3, 16'h5151);
    memw(12'h000, 16'h4444);
    fetch_start = 1'b1; ac_clr = 1'b1; dr_clr = 1'b1; mem_wr = 1'b1;
    bus_sel = 3'd4; branch_take = 1'b1;
    tick;
    chk("R7 T0 ar", {4'h0, ar_q}, 16'h0345);
    chk("R7 T0 busy", {15'h0, fetch_busy}, 16'h1);
    tick;
    chk("R7 T1 ir", ir_q, 16'h7ABC);
    chk("R7 T1 pc", {4'h0, pc_q}, 16'h0346);
    chk("R7 T1 busy", {15'h0, fetch_busy}, 16'h1);
    tick;
    clr_ctl;
    chk("R7 T2 ar", {4'h0, ar_q}, 16'h0ABC);
    chk("R7 T2 busy", {15'h0, fetch_busy}, 16'h0);
    chk("R8 pc no restart or branch", {4'h0, pc_q}, 16'h0346);
    chk("R8 ac kept", ac_q, 16'h2222);
    chk("R8 dr kept", dr_q, 16'h5151);
    ar_clr = 1'b1; tick; clr_ctl;
    bus_sel = 3'd7;
    #1 chk("R8 mem kept", bus_out, 16'h4444);
    clr_ctl;

    // R7: PC wrap during fetch
    memw(12'hFFF, 16'h1FFF);
    put(2, 16'h0FFF);
    fetch_start = 1'b1; tick; clr_ctl;
    repeat (2) tick;
    chk("R7 wrap ir", ir_q, 16'h1FFF);
    chk("R7 wrap pc", {4'h0, pc_q}, 16'h0000);
    chk("R7 wrap ar", {4'h0, ar_q}, 16'h0FFF);

    // R9: branch, external strobes ignored in that cycle
    put(5, 16'h5ABC);
    branch_take = 1'b1; pc_clr = 1'b1; ac_inr = 1'b1; tick; clr_ctl;
    chk("R9 branch pc", {4'h0, pc_q}, 16'h0ABC);
    chk("R8 ac kept in branch", ac_q, 16'h2222);

    // R9: fetch wins over branch
    put(5, 16'h6111);
    memw(12'hABC, 16'h0123);
    fetch_start = 1'b1; branch_take = 1'b1; tick; clr_ctl;
    chk("R9 fetch wins pc", {4'h0, pc_q}, 16'h0ABC);
    chk("R9 fetch wins ar", {4'h0, ar_q}, 16'h0ABC);
    repeat (2) tick;
    chk("R9 fetch ir", ir_q, 16'h0123);
    chk("R9 fetch pc", {4'h0, pc_q}, 16'h0ABD);
    chk("R9 fetch ar", {4'h0, ar_q}, 16'h0123);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule